// File: doc/BRIEF.md
# Interrupt Claim/Complete Arbiter

This block is the per-target decision engine of a platform-level interrupt controller. It watches a set of level-sensitive interrupt sources, numbered 1 upward. Number 0 is reserved and means "nothing". For each target context it keeps three things per source: a pending flag, the priority captured when that flag was set, and a claimed flag. From these it selects the best claimable source and raises the context's external-interrupt line when that source's captured priority is strictly above the context's threshold.

Software running on a context takes an interrupt by pulsing the claim strobe. In that cycle the block shows the selected id, and it then hides that source from arbitration. When the handler finishes, it pulses the complete strobe with the id, and the source becomes visible again. Lowering a source's level, or removing it from a context's enable set, cancels both the pending state and any claim held on it.

Register storage and address decoding belong to a separate register block. That block supplies the per-source priorities, the per-context enable vectors and thresholds, and the strobes.

With supervisor mode on, each hart owns two contexts. The even context drives the hart's machine-level line and the odd context drives its supervisor-level line. With supervisor mode off, every context drives a machine-level line of its own.

Top module: `irq_claim_arbiter`

## Requirements
- R1: Synchronous active-high reset clears all pending, captured-priority, claimed and previous-level state, so every notification line is 0 and every claim id output is 0.
- R2: When a source's level rises while a context has it enabled, the source becomes pending for that context on the next clock edge with the priority it has at that edge. Later changes to the source priority do not alter the captured value.
- R3: The selected id of a context is the pending, unclaimed source with the highest captured priority. Ties go to the lowest id, a candidate with captured priority 0 is still selected, and id 0 means no candidate.
- R4: A context's notification line is 1 exactly when its selected id is non-zero and the captured priority of that id is strictly greater than the context threshold.
- R5: The claim id output always shows the current selected id. A claim strobe marks that id claimed at the clock edge, and the id is then excluded from selection. A claim while the selected id is 0 changes nothing.
- R6: A complete strobe clears the claimed flag of the given id only when the id is below NUM_IDS and the source is enabled for that context. Ids 0, ids of NUM_IDS or more, and ids not enabled for the context are ignored.
- R7: When a source's level falls, its pending flag, captured priority and claimed flag are cleared in every context at the next edge, so a later rise makes it claimable again.
- R8: Enabling a source whose level is high makes it pending with its current priority. Disabling a source clears its pending flag, captured priority and claimed flag.
- R9: Source 0 never becomes pending: level bit 0 and enable bit 0 are ignored.
- R10: With SMODE=1, context 2h drives m_irq_o[h] and context 2h+1 drives s_irq_o[h]. With SMODE=0, context h drives m_irq_o[h] and s_irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_level_i | input | NUM_IDS | Source level lines; bit i is id i |
| src_prio_i | input | NUM_IDS*PRIO_W | Priority of id i at bits [i*PRIO_W +: PRIO_W] |
| ctx_enable_i | input | NUM_CTX*NUM_IDS | Enable of id i for context c at bit c*NUM_IDS+i |
| ctx_thresh_i | input | NUM_CTX*PRIO_W | Threshold of context c at [c*PRIO_W +: PRIO_W] |
| claim_req_i | input | NUM_CTX | One-cycle claim strobe per context |
| claim_id_o | output | NUM_CTX*ID_W | Selected id of context c at [c*ID_W +: ID_W] |
| cmpl_req_i | input | NUM_CTX | One-cycle complete strobe per context |
| cmpl_id_i | input | NUM_CTX*ID_W | Id to complete for context c at [c*ID_W +: ID_W] |
| m_irq_o | output | NUM_HART | Machine-level external interrupt line per hart |
| s_irq_o | output | NUM_HART | Supervisor-level external interrupt line per hart |

## Verification
Changes on the level, enable and strobe inputs reach the pending and claimed state at the first rising edge after they are driven. The selected id and the notification lines are combinational from that state and from the threshold, so a threshold change shows in the same cycle. The bench drives inputs on the falling edge and lets one rising edge pass before it samples state-dependent results. It reads a claim's returned id one time unit after raising the strobe, before the edge that records the claim, and it reads threshold effects without waiting for an edge.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  // Id field carries one extra bit so that out-of-range completes can be expressed
  function automatic int id_width(input int n_ids);
    return $clog2(n_ids) + 1;
  endfunction

  function automatic int hart_count(input int n_ctx, input int smode);
    return (smode != 0) ? (n_ctx / 2) : n_ctx;
  endfunction

  // Notification rule: a real candidate whose captured priority beats the threshold
  function automatic logic irq_due(input logic has_cand, input int cap_prio, input int thresh);
    return has_cand && (cap_prio > thresh);
  endfunction

endpackage

// File: rtl/irqarb_ctx_state.sv
module irqarb_ctx_state #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IDS-1:0]        lvl,
  input  logic [NUM_IDS-1:0]        lvl_rise,
  input  logic [NUM_IDS-1:0]        lvl_fall,
  input  logic [NUM_IDS-1:0]        enable,
  input  logic [NUM_IDS*PRIO_W-1:0] src_prio,
  input  logic                      claim,
  input  logic [ID_W-1:0]           sel_id,
  input  logic                      cmpl,
  input  logic [ID_W-1:0]           cmpl_id,
  output logic [NUM_IDS-1:0]        pend_q,
  output logic [NUM_IDS*PRIO_W-1:0] cap_prio_q,
  output logic [NUM_IDS-1:0]        claimed_q
);
  localparam int IDX_W = $clog2(NUM_IDS);

  logic [NUM_IDS-1:0]        en_eff, en_q, en_rise, en_drop, kill;
  logic [NUM_IDS-1:0]        pend_d, claimed_d;
  logic [NUM_IDS*PRIO_W-1:0] cap_prio_d;
  logic [IDX_W-1:0]          cmpl_idx, sel_idx;
  logic                      cmpl_ok;

  // Source 0 can never be enabled
  assign en_eff   = enable & ~{{(NUM_IDS-1){1'b0}}, 1'b1};
  assign en_rise  = en_eff & ~en_q;
  assign en_drop  = en_q & ~en_eff;
  assign kill     = lvl_fall | en_drop;
  assign cmpl_idx = cmpl_id[IDX_W-1:0];
  assign sel_idx  = sel_id[IDX_W-1:0];
  assign cmpl_ok  = cmpl && (int'(cmpl_id) < NUM_IDS) && en_eff[cmpl_idx];

  always_comb begin
    pend_d     = pend_q;
    cap_prio_d = cap_prio_q;
    claimed_d  = claimed_q;
    if (cmpl_ok) claimed_d[cmpl_idx] = 1'b0;
    if (claim && (sel_id != '0)) claimed_d[sel_idx] = 1'b1;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (kill[i]) begin
        pend_d[i]                    = 1'b0;
        cap_prio_d[i*PRIO_W +: PRIO_W] = '0;
        claimed_d[i]                 = 1'b0;
      end else if ((lvl_rise[i] && en_eff[i]) || (en_rise[i] && lvl[i])) begin
        pend_d[i]                    = 1'b1;
        cap_prio_d[i*PRIO_W +: PRIO_W] = src_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      pend_q     <= '0;
      cap_prio_q <= '0;
      claimed_q  <= '0;
    end else begin
      en_q       <= en_eff;
      pend_q     <= pend_d;
      cap_prio_q <= cap_prio_d;
      claimed_q  <= claimed_d;
    end
  end

  // R7 R8
  pend_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (|kill) |=> ((pend_q & $past(kill)) == '0));

  // R5 R6
  claimed_subset_chk: assert property (@(posedge clk) disable iff (rst)
    ((claimed_q & ~pend_q) == '0));

  // R9
  src0_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !claimed_q[0]);

endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IDS-1:0]        cand,
  input  logic [NUM_IDS*PRIO_W-1:0] cap_prio,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  logic found;

  // Ascending scan: only a strictly greater priority displaces the current choice
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    found     = 1'b0;
    for (int i = 1; i < NUM_IDS; i++) begin
      if (cand[i] && (!found || (cap_prio[i*PRIO_W +: PRIO_W] > best_prio))) begin
        best_id   = ID_W'(i);
        best_prio = cap_prio[i*PRIO_W +: PRIO_W];
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqarb_line_map.sv
module irqarb_line_map #(
  parameter int NUM_CTX  = 4,
  parameter int SMODE    = 1,
  parameter int NUM_HART = 2
) (
  input  logic [NUM_CTX-1:0]  ctx_irq,
  output logic [NUM_HART-1:0] m_irq,
  output logic [NUM_HART-1:0] s_irq
);
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    if (SMODE != 0) begin : g_split
      assign m_irq[h] = ctx_irq[2*h];
      assign s_irq[h] = ctx_irq[2*h+1];
    end else begin : g_flat
      assign m_irq[h] = ctx_irq[h];
      assign s_irq[h] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
  parameter int NUM_IDS  = 32,
  parameter int NUM_CTX  = 4,
  parameter int PRIO_W   = 3,
  parameter int SMODE    = 1,
  localparam int ID_W     = irqarb_pkg::id_width(NUM_IDS),
  localparam int NUM_HART = irqarb_pkg::hart_count(NUM_CTX, SMODE)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IDS-1:0]        src_level_i,
  input  logic [NUM_IDS*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_CTX*NUM_IDS-1:0] ctx_enable_i,
  input  logic [NUM_CTX*PRIO_W-1:0] ctx_thresh_i,
  input  logic [NUM_CTX-1:0]        claim_req_i,
  output logic [NUM_CTX*ID_W-1:0]   claim_id_o,
  input  logic [NUM_CTX-1:0]        cmpl_req_i,
  input  logic [NUM_CTX*ID_W-1:0]   cmpl_id_i,
  output logic [NUM_HART-1:0]       m_irq_o,
  output logic [NUM_HART-1:0]       s_irq_o
);
  localparam int IDX_W = $clog2(NUM_IDS);

  logic [NUM_IDS-1:0] lvl, lvl_q, lvl_rise, lvl_fall;
  logic [NUM_CTX-1:0] ctx_irq;

  logic [NUM_CTX-1:0][NUM_IDS-1:0]        pend_w, claimed_w;
  logic [NUM_CTX-1:0][NUM_IDS*PRIO_W-1:0] cap_w;
  logic [NUM_CTX-1:0][ID_W-1:0]           best_w;
  logic [NUM_CTX-1:0][PRIO_W-1:0]         bprio_w;

  assign lvl      = src_level_i & ~{{(NUM_IDS-1){1'b0}}, 1'b1};
  assign lvl_rise = lvl & ~lvl_q;
  assign lvl_fall = lvl_q & ~lvl;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irqarb_ctx_state #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) state_i (
      .clk        (clk),
      .rst        (rst),
      .lvl        (lvl),
      .lvl_rise   (lvl_rise),
      .lvl_fall   (lvl_fall),
      .enable     (ctx_enable_i[c*NUM_IDS +: NUM_IDS]),
      .src_prio   (src_prio_i),
      .claim      (claim_req_i[c]),
      .sel_id     (best_w[c]),
      .cmpl       (cmpl_req_i[c]),
      .cmpl_id    (cmpl_id_i[c*ID_W +: ID_W]),
      .pend_q     (pend_w[c]),
      .cap_prio_q (cap_w[c]),
      .claimed_q  (claimed_w[c])
    );

    irqarb_pick #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) pick_i (
      .cand      (pend_w[c] & ~claimed_w[c]),
      .cap_prio  (cap_w[c]),
      .best_id   (best_w[c]),
      .best_prio (bprio_w[c])
    );

    assign claim_id_o[c*ID_W +: ID_W] = best_w[c];
    assign ctx_irq[c] = irqarb_pkg::irq_due(best_w[c] != '0, int'(bprio_w[c]),
                                            int'(ctx_thresh_i[c*PRIO_W +: PRIO_W]));

    // R3
    pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (best_w[c] != '0) |-> (pend_w[c][best_w[c][IDX_W-1:0]] && !claimed_w[c][best_w[c][IDX_W-1:0]]));

    // R5
    claim_marks_chk: assert property (@(posedge clk) disable iff (rst)
      (claim_req_i[c] && (best_w[c] != '0) && !lvl_fall[best_w[c][IDX_W-1:0]]
       && ctx_enable_i[c*NUM_IDS + int'(best_w[c][IDX_W-1:0])])
      |=> claimed_w[c][$past(best_w[c][IDX_W-1:0])]);
  end

  irqarb_line_map #(.NUM_CTX(NUM_CTX), .SMODE(SMODE), .NUM_HART(NUM_HART)) map_i (
    .ctx_irq (ctx_irq),
    .m_irq   (m_irq_o),
    .s_irq   (s_irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> ((m_irq_o == '0) && (s_irq_o == '0) && (claim_id_o == '0)));

endmodule

// File: tb/irq_claim_arbiter_tb_top.sv
module irq_claim_arbiter_tb_top;
  localparam int NI = 32, NC = 4, PW = 3, IW = 6, NH = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NI-1:0]     lvl = '0;
  logic [NI*PW-1:0]  prio = '0;
  logic [NC*NI-1:0]  en = '0;
  logic [NC*PW-1:0]  th = '0;
  logic [NC-1:0]     clm = '0;
  logic [NC*IW-1:0]  cid;
  logic [NC-1:0]     cmp = '0;
  logic [NC*IW-1:0]  cmp_id = '0;
  logic [NH-1:0]     m_irq, s_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_claim_arbiter #(.NUM_IDS(NI), .NUM_CTX(NC), .PRIO_W(PW), .SMODE(1)) dut_i (
    .clk(clk), .rst(rst), .src_level_i(lvl), .src_prio_i(prio), .ctx_enable_i(en),
    .ctx_thresh_i(th), .claim_req_i(clm), .claim_id_o(cid), .cmpl_req_i(cmp),
    .cmpl_id_i(cmp_id), .m_irq_o(m_irq), .s_irq_o(s_irq));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int id_of(input int c);
    return int'(cid[c*IW +: IW]);
  endfunction

  // even context -> machine line of hart c/2, odd -> supervisor line
  function automatic int irq_of(input int c);
    return (c % 2 == 1) ? int'(s_irq[c/2]) : int'(m_irq[c/2]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_en(input int c, input int id, input bit v);
    en[c*NI + id] = v;
  endtask

  task automatic set_prio(input int id, input int p);
    prio[id*PW +: PW] = PW'(p);
  endtask

  task automatic set_th(input int c, input int t);
    th[c*PW +: PW] = PW'(t);
  endtask

  task automatic do_claim(input int c, output int got);
    clm[c] = 1'b1;
    #1 got = id_of(c);
    step();
    clm[c] = 1'b0;
  endtask

  task automatic do_cmpl(input int c, input int id);
    cmp[c] = 1'b1;
    cmp_id[c*IW +: IW] = IW'(id);
    step();
    cmp[c] = 1'b0;
  endtask

  task automatic restart();
    lvl = '0; prio = '0; en = '0; th = '0; clm = '0; cmp = '0; cmp_id = '0;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    restart();
    for (int c = 0; c < NC; c++) begin
      check("R1 id after reset", id_of(c), 0);
      check("R1 irq after reset", irq_of(c), 0);
    end
  endtask

  task automatic t_capture();
    restart();
    set_en(0, 7, 1); set_prio(7, 3); lvl[7] = 1'b1;
    #1 check("R2 not pending before edge", id_of(0), 0);
    step();
    check("R2 pending after one edge", id_of(0), 7);
    check("R2 irq raised", irq_of(0), 1);
    set_th(0, 2); set_prio(7, 0);
    step();
    check("R2 captured prio kept", irq_of(0), 1);
  endtask

  task automatic t_arbitrate();
    int got;
    restart();
    set_en(2, 4, 1); set_en(2, 9, 1); set_en(2, 12, 1);
    set_prio(4, 2); set_prio(9, 5); set_prio(12, 5);
    lvl[4] = 1; lvl[9] = 1; lvl[12] = 1;
    step();
    check("R3 tie to lowest id", id_of(2), 9);
    do_claim(2, got); check("R5 claim returns best", got, 9);
    check("R5 claimed hidden", id_of(2), 12);
    do_claim(2, got); check("R5 second claim", got, 12);
    check("R3 lower prio next", id_of(2), 4);
    do_claim(2, got); check("R5 third claim", got, 4);
    check("R5 all claimed id", id_of(2), 0);
    check("R4 irq low when none", irq_of(2), 0);
    do_claim(2, got); check("R5 empty claim returns 0", got, 0);
    check("R5 empty claim no change", id_of(2), 0);
    do_cmpl(2, 12);
    check("R6 complete releases", id_of(2), 12);
  endtask

  task automatic t_thresh();
    restart();
    set_en(0, 3, 1); set_prio(3, 2); set_th(0, 2); lvl[3] = 1;
    step();
    check("R4 id shown below threshold", id_of(0), 3);
    check("R4 equal to threshold no irq", irq_of(0), 0);
    set_th(0, 1);
    #1 check("R4 above threshold irq", irq_of(0), 1);
  endtask

  task automatic t_zero_prio();
    restart();
    set_en(0, 5, 1); lvl[5] = 1;
    step();
    check("R3 prio 0 candidate selected", id_of(0), 5);
    check("R4 prio 0 no irq", irq_of(0), 0);
    set_en(0, 2, 1); lvl[2] = 1;
    step();
    check("R3 prio 0 tie lowest id", id_of(0), 2);
  endtask

  task automatic t_complete();
    int got;
    restart();
    set_en(1, 6, 1); set_prio(6, 4); lvl[6] = 1; set_en(1, 8, 0);
    step();
    do_claim(1, got); check("R5 claim ctx1", got, 6);
    check("R5 irq after claim", irq_of(1), 0);
    do_cmpl(1, 0);  check("R6 complete id 0 ignored", id_of(1), 0);
    do_cmpl(1, 40); check("R6 complete out of range ignored", id_of(1), 0);
    do_cmpl(1, 8);  check("R6 complete unenabled ignored", id_of(1), 0);
    do_cmpl(1, 6);  check("R6 complete valid", id_of(1), 6);
    check("R6 irq back", irq_of(1), 1);
  endtask

  task automatic t_fall();
    int got;
    restart();
    set_en(3, 10, 1); set_prio(10, 3); lvl[10] = 1;
    step();
    do_claim(3, got); check("R5 claim ctx3", got, 10);
    lvl[10] = 0;
    step();
    check("R7 fall clears", id_of(3), 0);
    lvl[10] = 1;
    step();
    check("R7 claim cancelled by fall", id_of(3), 10);
    check("R7 irq after re-rise", irq_of(3), 1);
  endtask

  task automatic t_enable();
    int got;
    restart();
    set_prio(11, 6); lvl[11] = 1;
    step();
    check("R8 not enabled not pending", id_of(2), 0);
    set_en(2, 11, 1);
    step();
    check("R8 enable while high", id_of(2), 11);
    check("R8 irq on enable", irq_of(2), 1);
    do_claim(2, got); check("R8 claim", got, 11);
    set_en(2, 11, 0);
    step();
    check("R8 disabled id", id_of(2), 0);
    set_prio(11, 1); set_th(2, 2); set_en(2, 11, 1);
    step();
    check("R8 claim cancelled by disable", id_of(2), 11);
    check("R8 current prio captured", irq_of(2), 0);
  endtask

  task automatic t_src0();
    restart();
    lvl[0] = 1;
    for (int c = 0; c < NC; c++) set_en(c, 0, 1);
    step(); step();
    for (int c = 0; c < NC; c++) begin
      check("R9 source 0 id", id_of(c), 0);
      check("R9 source 0 irq", irq_of(c), 0);
    end
  endtask

  task automatic t_map();
    int got;
    restart();
    set_en(1, 13, 1); set_prio(13, 1); lvl[13] = 1;
    step();
    check("R10 s_irq[0]", int'(s_irq[0]), 1);
    check("R10 m_irq[0]", int'(m_irq[0]), 0);
    check("R10 m_irq[1]", int'(m_irq[1]), 0);
    check("R10 s_irq[1]", int'(s_irq[1]), 0);
    set_en(0, 13, 1);
    step();
    check("R10 m_irq[0] shared source", int'(m_irq[0]), 1);
    do_claim(0, got);
    check("R10 ctx1 unaffected by ctx0 claim", id_of(1), 13);
    check("R10 m_irq[0] after claim", int'(m_irq[0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_capture();
    t_arbitrate();
    t_thresh();
    t_zero_prio();
    t_complete();
    t_fall();
    t_enable();
    t_src0();
    t_map();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule